// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block turns a request to scale one display plane into the setup values that a polyphase scaling engine needs. It takes a mask of the planes that want scaling, the source width and height in unsigned 16.16 fixed point, and the destination width and height in whole pixels. From these it produces a scale enable, the index of the plane to scale, an enhancer enable, and an initial phase and a per-pixel phase step for each axis.

A request is made by pulsing `start`. When no division is needed, the result appears one cycle later. This covers an empty mask and every error case. Otherwise the block runs four divisions in turn on one restoring divider that produces one quotient bit per cycle, and holds `busy` high until they finish. `done` pulses for one cycle when the outputs take their new values. The outputs then hold until the next completed request. The enhancer decision needs no division, because it comes from a comparison on the inputs.

Top module: `sp_phase_calc`

## Requirements
- R1: When `start` is accepted with `plane_mask` equal to zero, `done` pulses in the next cycle with `err`=0, `scale_en`=0, `enh_en`=0, `plane_id`=0 and all four phase outputs 0. This holds even when a size is zero.
- R2: When `start` is accepted with two or more mask bits set, `done` pulses in the next cycle with `err`=1, `scale_en`=0 and all other result outputs 0.
- R3: With exactly one mask bit set, `done` pulses in the next cycle with `err`=1, `scale_en`=0 and all other result outputs 0 if any of these is zero: `dst_w`, `dst_h`, the full 16.16 `src_w` or the full 16.16 `src_h`.
- R4: For a valid request (one mask bit set, no zero size), `done` reports `err`=0 and `scale_en`=1, and `plane_id` holds the bit position of the set mask bit (bit 0 gives 0).
- R5: The initial phase of each axis is ((N*16)/D + 1)/2, using integer division. N is the integer part (upper 16 bits) of the source size for that axis, and D is the destination size. Fraction bits do not affect the phases.
- R6: The phase step of each axis is (N*65536)/D, using integer division.
- R7: `enh_en` is 1 when the integer part of either axis's upscale factor is 2 or more, and 0 otherwise. The upscale factor is floor(D*2^32 / S), read as 16.16, where S is the 16.16 source size.
- R8: `busy` is high from the cycle after an accepted start of a valid request until `done`. `done` lasts exactly one cycle. A `start` that arrives while `busy` is high is ignored.
- R9: The result outputs (`err`, `scale_en`, `plane_id`, `enh_en`, the four phases) change only in a cycle in which `done` is high.
- R10: After reset, `busy`, `done` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| plane_mask | input | PLANES | Planes requesting scaling |
| src_w | input | INT_W+FRAC_W | Source width, 16.16 |
| src_h | input | INT_W+FRAC_W | Source height, 16.16 |
| dst_w | input | DIM_W | Destination width in pixels |
| dst_h | input | DIM_W | Destination height in pixels |
| busy | output | 1 | Divisions in progress |
| done | output | 1 | One-cycle pulse when results update |
| err | output | 1 | Request rejected |
| scale_en | output | 1 | Scaling enabled |
| plane_id | output | ID_W | Index of the plane to scale |
| enh_en | output | 1 | Enhancer enable |
| h_init | output | NUM_W | Horizontal initial phase |
| h_delta | output | NUM_W | Horizontal phase step |
| v_init | output | NUM_W | Vertical initial phase |
| v_delta | output | NUM_W | Vertical phase step |

## Verification
The bench builds the block with its defaults: four planes, 16.16 source sizes and 16-bit destination sizes. With these settings, every plane index can be selected. A source integer part of 65535 against a destination of 1 drives the phase step to the top of its 32-bit range. The tests also cover the exact ratio-2 boundary of the enhancer in both directions, on integer and on fractional sources. Because a zero mask and a bad mask finish in one cycle, the bench can also check them against a zero size, and check that a start arriving during a long division run is ignored.

// File: rtl/sp_pkg.sv
package sp_pkg;
    // Number of divisions issued per valid request, in issue order:
    // horizontal initial, horizontal step, vertical initial, vertical step
    localparam int N_DIV = 4;
    localparam int IDX_W = 2;

    typedef enum logic [IDX_W-1:0] {
        DIV_H_INIT = 2'd0,
        DIV_H_STEP = 2'd1,
        DIV_V_INIT = 2'd2,
        DIV_V_STEP = 2'd3
    } div_sel_e;
endpackage

// File: rtl/sp_mask_check.sv
module sp_mask_check #(
    parameter int PLANES = 4,
    parameter int ID_W   = 2
) (
    input  logic [PLANES-1:0] mask,
    output logic              none_set,
    output logic              many_set,
    output logic [ID_W-1:0]   sel_id
);
    localparam int CNT_W = $clog2(PLANES + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones   = '0;
        sel_id = '0;
        for (int i = 0; i < PLANES; i++) begin
            if (mask[i]) begin
                ones   = ones + 1'b1;
                sel_id = ID_W'(i);
            end
        end
        none_set = (ones == '0);
        many_set = (ones > CNT_W'(1));
    end
endmodule

// File: rtl/sp_divider.sv
module sp_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] acc;   // dividend bits shift out, quotient bits shift in
    } div_t;

    div_t q, d;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           qbit;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.acc[NUM_W-1]};
        diff   = trial - {1'b0, q.den};
        qbit   = (trial >= {1'b0, q.den});
        if (q.busy) begin
            d.rem = qbit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            d.acc = {q.acc[NUM_W-2:0], qbit};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end else if (go) begin
            d.busy = 1'b1;
            d.acc  = num;
            d.rem  = '0;
            d.den  = den;
            d.cnt  = CNT_W'(NUM_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;
    assign quo  = q.acc;

    // Partial remainder always stays below a non-zero divisor
    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.den != '0) |-> (q.rem < q.den)); // R6
    AST_DIV_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
endmodule

// File: rtl/sp_phase_calc.sv
module sp_phase_calc #(
    parameter int PLANES      = 4,
    parameter int INT_W       = 16,
    parameter int FRAC_W      = 16,
    parameter int DIM_W       = 16,
    parameter int PH_BITS     = 4,
    parameter int EXTRA_SHIFT = 12,
    localparam int SRC_W      = INT_W + FRAC_W,
    localparam int NUM_W      = INT_W + PH_BITS + EXTRA_SHIFT,
    localparam int ID_W       = (PLANES > 1) ? $clog2(PLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PLANES-1:0] plane_mask,
    input  logic [SRC_W-1:0]  src_w,
    input  logic [SRC_W-1:0]  src_h,
    input  logic [DIM_W-1:0]  dst_w,
    input  logic [DIM_W-1:0]  dst_h,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              scale_en,
    output logic [ID_W-1:0]   plane_id,
    output logic              enh_en,
    output logic [NUM_W-1:0]  h_init,
    output logic [NUM_W-1:0]  h_delta,
    output logic [NUM_W-1:0]  v_init,
    output logic [NUM_W-1:0]  v_delta
);
    import sp_pkg::*;

    localparam int CMP_W = DIM_W + SRC_W;
    localparam int LOW_Z = NUM_W - INT_W - PH_BITS;

    typedef struct packed {
        logic       err;
        logic       scale_en;
        logic [ID_W-1:0] plane_id;
        logic       enh_en;
        logic [NUM_W-1:0] h_init;
        logic [NUM_W-1:0] h_delta;
        logic [NUM_W-1:0] v_init;
        logic [NUM_W-1:0] v_delta;
    } res_t;

    typedef struct packed {
        logic       busy;
        logic       done;
        logic       go;
        div_sel_e   sel;
        logic [INT_W-1:0] in_w;
        logic [INT_W-1:0] in_h;
        logic [DIM_W-1:0] ow;
        logic [DIM_W-1:0] oh;
        logic [ID_W-1:0]  pid;
        logic       enh;
        logic [N_DIV-1:0][NUM_W-1:0] wk;
        res_t       res;
    } top_t;

    top_t q, d;

    logic             m_none, m_many;
    logic [ID_W-1:0]  m_id;
    logic             div_busy, div_done;
    logic [NUM_W-1:0] div_quo, div_num;
    logic [DIM_W-1:0] div_den;
    logic             enh_now, bad_size;
    logic [NUM_W:0]   hi_round, vi_round;

    sp_mask_check #(.PLANES(PLANES), .ID_W(ID_W)) i_mask (
        .mask(plane_mask), .none_set(m_none), .many_set(m_many), .sel_id(m_id)
    );

    sp_divider #(.NUM_W(NUM_W), .DEN_W(DIM_W)) i_div (
        .clk(clk), .rst_n(rst_n), .go(q.go), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(div_quo)
    );

    // Integer part of D*2^(2F)/S is >= 2 exactly when D*2^(F-1) >= S
    always_comb begin
        enh_now  = (CMP_W'({dst_w, {(FRAC_W-1){1'b0}}}) >= CMP_W'(src_w))
                || (CMP_W'({dst_h, {(FRAC_W-1){1'b0}}}) >= CMP_W'(src_h));
        bad_size = (dst_w == '0) || (dst_h == '0) || (src_w == '0) || (src_h == '0);
    end

    always_comb begin
        case (q.sel)
            DIV_H_INIT: div_num = {{LOW_Z{1'b0}}, q.in_w, {PH_BITS{1'b0}}};
            DIV_H_STEP: div_num = {q.in_w, {(PH_BITS+EXTRA_SHIFT){1'b0}}};
            DIV_V_INIT: div_num = {{LOW_Z{1'b0}}, q.in_h, {PH_BITS{1'b0}}};
            default:    div_num = {q.in_h, {(PH_BITS+EXTRA_SHIFT){1'b0}}};
        endcase
        div_den = (q.sel == DIV_H_INIT || q.sel == DIV_H_STEP) ? q.ow : q.oh;
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.go     = 1'b0;
        hi_round = {1'b0, q.wk[DIV_H_INIT]} + (NUM_W+1)'(1);
        vi_round = {1'b0, q.wk[DIV_V_INIT]} + (NUM_W+1)'(1);
        if (!q.busy) begin
            if (start) begin
                if (m_none) begin
                    d.done = 1'b1;
                    d.res  = '0;
                end else if (m_many || bad_size) begin
                    d.done    = 1'b1;
                    d.res     = '0;
                    d.res.err = 1'b1;
                end else begin
                    d.busy = 1'b1;
                    d.go   = 1'b1;
                    d.sel  = DIV_H_INIT;
                    d.in_w = src_w[SRC_W-1:FRAC_W];
                    d.in_h = src_h[SRC_W-1:FRAC_W];
                    d.ow   = dst_w;
                    d.oh   = dst_h;
                    d.pid  = m_id;
                    d.enh  = enh_now;
                end
            end
        end else if (div_done) begin
            d.wk[q.sel] = div_quo;
            if (q.sel == DIV_V_STEP) begin
                d.busy             = 1'b0;
                d.done             = 1'b1;
                d.res.err          = 1'b0;
                d.res.scale_en     = 1'b1;
                d.res.plane_id     = q.pid;
                d.res.enh_en       = q.enh;
                d.res.h_init       = hi_round[NUM_W:1];
                d.res.h_delta      = q.wk[DIV_H_STEP];
                d.res.v_init       = vi_round[NUM_W:1];
                d.res.v_delta      = div_quo;
            end else begin
                d.sel = div_sel_e'(q.sel + 1'b1);
                d.go  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign err      = q.res.err;
    assign scale_en = q.res.scale_en;
    assign plane_id = q.res.plane_id;
    assign enh_en   = q.res.enh_en;
    assign h_init   = q.res.h_init;
    assign h_delta  = q.res.h_delta;
    assign v_init   = q.res.v_init;
    assign v_delta  = q.res.v_delta;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy != done)); // R8
    AST_NO_DIV_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({err, scale_en, plane_id, enh_en, h_init, h_delta, v_init, v_delta})); // R9
    AST_ERR_NO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> !scale_en); // R2
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !$past(busy) && $past(plane_mask) == '0) |-> (done && !err && !scale_en)); // R1
endmodule

// File: tb/test_sp_phase_calc.sv
module test_sp_phase_calc;
    localparam int PLANES = 4;
    localparam int NUM_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PLANES-1:0] plane_mask = '0;
    logic [31:0]       src_w = '0, src_h = '0;
    logic [15:0]       dst_w = '0, dst_h = '0;
    logic              busy, done, err, scale_en, enh_en;
    logic [1:0]        plane_id;
    logic [NUM_W-1:0]  h_init, h_delta, v_init, v_delta;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Model of the held result outputs
    longint e_err = 0, e_scale = 0, e_id = 0, e_enh = 0;
    longint e_hi = 0, e_hd = 0, e_vi = 0, e_vd = 0;

    always #10 clk = ~clk;

    sp_phase_calc i_sp_phase_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .plane_mask(plane_mask),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .busy(busy), .done(done), .err(err), .scale_en(scale_en),
        .plane_id(plane_id), .enh_en(enh_en), .h_init(h_init), .h_delta(h_delta),
        .v_init(v_init), .v_delta(v_delta)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        chk(err == e_err[0],        req, "err",      err,      e_err);
        chk(scale_en == e_scale[0], req, "scale_en", scale_en, e_scale);
        chk(plane_id == e_id,       req, "plane_id", plane_id, e_id);
        chk(enh_en == e_enh[0],     req, "enh_en",   enh_en,   e_enh);
        chk(h_init == e_hi,         req, "h_init",   h_init,   e_hi);
        chk(h_delta == e_hd,        req, "h_delta",  h_delta,  e_hd);
        chk(v_init == e_vi,         req, "v_init",   v_init,   e_vi);
        chk(v_delta == e_vd,        req, "v_delta",  v_delta,  e_vd);
    endtask

    // R9: outside a done cycle the outputs keep the last expected values
    always @(negedge clk) begin
        if (rst_n && !done && !finished) begin
            checks++;
            if ({err, scale_en, enh_en} != {e_err[0], e_scale[0], e_enh[0]} ||
                plane_id != e_id || h_init != e_hi || h_delta != e_hd ||
                v_init != e_vi || v_delta != e_vd) begin
                errors++;
                $display("FAIL R9 held outputs: actual %0h/%0h expected %0h/%0h",
                         h_delta, v_delta, e_hd, e_vd);
            end
        end
    end

    // Behavioural expectation from the requirements
    task automatic model(input logic [3:0] m, input longint sw, input longint sh,
                         input longint dw, input longint dh, output bit quick);
        int ones = 0;
        int pos = 0;
        longint iw, ih;
        for (int i = 0; i < PLANES; i++) if (m[i]) begin ones++; pos = i; end
        e_err = 0; e_scale = 0; e_id = 0; e_enh = 0;
        e_hi = 0; e_hd = 0; e_vi = 0; e_vd = 0;
        quick = 1'b1;
        if (ones == 0) return;
        if (ones > 1 || dw == 0 || dh == 0 || sw == 0 || sh == 0) begin
            e_err = 1;
            return;
        end
        quick = 1'b0;
        iw = sw >> 16;
        ih = sh >> 16;
        e_scale = 1;
        e_id = pos;
        e_hi = (((iw << 4) / dw) + 1) / 2;
        e_hd = (iw << 16) / dw;
        e_vi = (((ih << 4) / dh) + 1) / 2;
        e_vd = (ih << 16) / dh;
        e_enh = ((((dw << 32) / sw) >> 16) >= 2 || (((dh << 32) / sh) >> 16) >= 2) ? 1 : 0;
    endtask

    task automatic run(input logic [3:0] m, input logic [31:0] sw, input logic [31:0] sh,
                       input logic [15:0] dw, input logic [15:0] dh, input string req,
                       input bit poke_busy);
        bit quick;
        int wait_n = 0;
        longint n_err, n_scale, n_id, n_enh, n_hi, n_hd, n_vi, n_vd;
        longint o_err, o_scale, o_id, o_enh, o_hi, o_hd, o_vi, o_vd;
        @(negedge clk);
        plane_mask = m; src_w = sw; src_h = sh; dst_w = dw; dst_h = dh;
        start = 1'b1;
        o_err = e_err; o_scale = e_scale; o_id = e_id; o_enh = e_enh;
        o_hi = e_hi; o_hd = e_hd; o_vi = e_vi; o_vd = e_vd;
        model(m, sw, sh, dw, dh, quick);
        n_err = e_err; n_scale = e_scale; n_id = e_id; n_enh = e_enh;
        n_hi = e_hi; n_hd = e_hd; n_vi = e_vi; n_vd = e_vd;
        // keep held values until done is observed
        e_err = o_err; e_scale = o_scale; e_id = o_id; e_enh = o_enh;
        e_hi = o_hi; e_hd = o_hd; e_vi = o_vi; e_vd = o_vd;
        @(negedge clk);
        start = 1'b0;
        if (quick) begin
            chk(done == 1'b1 && busy == 1'b0, req, "done one cycle after start",
                {done, busy}, 2'b10);
        end else begin
            chk(busy == 1'b1 && done == 1'b0, "R8", "busy after start", {busy, done}, 2'b10);
            if (poke_busy) begin
                // R8: a start during busy with an empty mask must be ignored
                repeat (5) @(negedge clk);
                plane_mask = '0; dst_w = '0; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(busy == 1'b1 && done == 1'b0, "R8", "start ignored while busy",
                    {busy, done}, 2'b10);
            end
            while (!done && wait_n < 1000) begin
                @(negedge clk);
                wait_n++;
            end
        end
        e_err = n_err; e_scale = n_scale; e_id = n_id; e_enh = n_enh;
        e_hi = n_hi; e_hd = n_hd; e_vi = n_vi; e_vd = n_vd;
        chk(done == 1'b1, req, "done seen", done, 1);
        cmp_all(req);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8", "done lasts one cycle", {done, busy}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done in reset", {busy, done}, 0);
        cmp_all("R10");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R10");

        // R1: empty mask wins over a zero destination
        run(4'b0000, {16'd640, 16'd0}, {16'd480, 16'd0}, 16'd0, 16'd480, "R1", 1'b0);
        // R2: two bits set
        run(4'b0101, {16'd640, 16'd0}, {16'd480, 16'd0}, 16'd640, 16'd480, "R2", 1'b0);
        // R3: zero destination width, then zero source height
        run(4'b0010, {16'd640, 16'd0}, {16'd480, 16'd0}, 16'd0, 16'd480, "R3", 1'b0);
        run(4'b0010, {16'd640, 16'd0}, 32'd0, 16'd640, 16'd480, "R3", 1'b0);
        // R4 R5 R6: downscale on plane 0
        run(4'b0001, {16'd1920, 16'd0}, {16'd1080, 16'd0}, 16'd1280, 16'd720, "R5 R6", 1'b0);
        // R7: upscale x3 on plane 3
        run(4'b1000, {16'd640, 16'd0}, {16'd480, 16'd0}, 16'd1920, 16'd1440, "R4 R7", 1'b0);
        // R5: fraction bits ignored for phases
        run(4'b0100, {16'd100, 16'hC000}, {16'd77, 16'h0001}, 16'd33, 16'd150, "R5", 1'b0);
        // R7: exact ratio 2 on the vertical axis only
        run(4'b0010, {16'd800, 16'd0}, {16'd300, 16'd0}, 16'd800, 16'd600, "R7", 1'b0);
        // R7: one pixel below ratio 2
        run(4'b0010, {16'd800, 16'd0}, {16'd300, 16'd0}, 16'd800, 16'd599, "R7", 1'b0);
        // R7: fractional source, ratio exactly 2
        run(4'b0001, {16'd300, 16'h8000}, {16'd10, 16'd0}, 16'd601, 16'd10, "R7", 1'b0);
        // R6: widest step value
        run(4'b0100, {16'd65535, 16'hFFFF}, {16'd1, 16'd0}, 16'd1, 16'd65535, "R6", 1'b0);
        // R8: start while busy is ignored
        run(4'b0010, {16'd1024, 16'd0}, {16'd768, 16'd0}, 16'd333, 16'd999, "R8", 1'b1);
        // R1 after a valid result: outputs return to zero
        run(4'b0000, {16'd1, 16'd0}, {16'd1, 16'd0}, 16'd1, 16'd1, "R1", 1'b0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule